// File: doc/BRIEF.md
# Script Register Arithmetic Unit

This unit carries out the register read-modify-write class of a small channel-processor instruction set. It accepts one 32-bit instruction word and decodes three things from it: a routing, an operator and an operand source. It takes one byte either from a byte-wide register space or from a dedicated first-byte register. It combines that byte with an 8-bit immediate, or with the first-byte register, using one of eight operators. The result goes back to a register or to the first-byte register. A carry flag is kept across instructions, so multi-byte arithmetic and rotates can be chained.

The register space sits outside the unit behind a simple port. The unit drives a read strobe with an address and expects the byte back on the next clock edge. It drives a write strobe with an address and data, and the store happens on that edge. An instruction is offered by holding `insn_valid` high for one cycle while the unit is idle. The unit reports completion with a one-cycle `insn_done` pulse.

Top module: `script_reg_alu`

## Requirements
- R1: Bits 31:27 of the word pick the routing. 5'h0D (top byte 0x68..0x6F) writes register = SFBR op data. 5'h0E (0x70..0x77) writes SFBR = register op data. 5'h0F (0x78..0x7F) writes register = register op data. Any other routing, or any non-zero bit in 6:0, completes with no register write and no change to SFBR or carry.
- R2: Bits 26:24 pick the operator: 0 load data, 1 shift left, 2 OR, 3 XOR, 4 AND, 5 shift right, 6 add, 7 add with carry. Shifts act on the first operand (SFBR for routing 5'h0D, otherwise the register).
- R3: The data operand is the immediate in bits 15:8. When bit 23 is 1, the data operand is the current SFBR value instead.
- R4: The register offset is {bit 7, bits 22:16}, so offsets 0x80..0xFF are reachable. The offset is used for both the read and the write.
- R5: Add sets carry to bit 8 of the 9-bit sum. Add with carry also adds the current carry.
- R6: Shift left puts bit 7 into carry and the old carry into bit 0. Shift right puts bit 0 into carry and the old carry into bit 7.
- R7: Load, OR, XOR and AND leave carry unchanged.
- R8: If the routing reads a register, `rf_re` is high in the first cycle after the accepting edge. `rf_we` (register destination) is high in the second cycle. `insn_done` is high for exactly the third cycle.
- R9: `insn_valid` is ignored while an instruction is in progress.
- R10: Reset clears SFBR and carry and holds `insn_done`, `rf_re` and `rf_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction offered this cycle |
| insn_word | input | 32 | First instruction word |
| insn_done | output | 1 | One-cycle completion pulse |
| rf_re | output | 1 | Register read strobe |
| rf_we | output | 1 | Register write strobe |
| rf_addr | output | ADDR_W | Register offset for read and write |
| rf_wdata | output | 8 | Byte to write |
| rf_rdata | input | 8 | Byte read, valid the cycle after `rf_re` |
| sfbr_o | output | 8 | Current first-byte register |
| carry_o | output | 1 | Current carry flag |

## Verification
SFBR and carry have no direct write path, so the hardest cases to reach are the carry-in paths of add-with-carry and the two shifts. These need a carry of 1 left behind by an earlier instruction. The vector table is therefore ordered as a chain: overflowing adds and shifts set the carry, and the next rows consume it. Rows that use logical operators sit between carry-setting and carry-consuming rows, which shows that they leave carry alone. An offset with bit 7 set reaches the upper bank, and SFBR is loaded from a register before the rows that route through it.

// File: rtl/script_alu_pkg.sv
package script_alu_pkg;

    localparam logic [4:0] RT_CODE_S2R = 5'h0D;
    localparam logic [4:0] RT_CODE_R2S = 5'h0E;
    localparam logic [4:0] RT_CODE_R2R = 5'h0F;

    typedef enum logic [1:0] {
        RT_NONE,
        RT_S2R,
        RT_R2S,
        RT_R2R
    } route_e;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_SHL  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_AND  = 3'd4,
        OP_SHR  = 3'd5,
        OP_ADD  = 3'd6,
        OP_ADDC = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        route_e     route;
        alu_op_e    op;
        logic       use_sfbr;
        logic [7:0] imm;
        logic [7:0] off;
    } dec_t;

    typedef struct packed {
        fsm_e       fsm;
        dec_t       dec;
        logic [7:0] sfbr;
        logic       carry;
    } unit_state_t;

endpackage

// File: rtl/script_alu_decode.sv
module script_alu_decode
    import script_alu_pkg::*;
(
    input  logic [31:0] word_i,
    output dec_t        dec_o
);
    logic rsvd_nz;

    always_comb begin
        rsvd_nz        = |word_i[6:0];
        dec_o.op       = alu_op_e'(word_i[26:24]);
        dec_o.use_sfbr = word_i[23];
        dec_o.imm      = word_i[15:8];
        dec_o.off      = {word_i[7], word_i[22:16]};
        unique case (word_i[31:27])
            RT_CODE_S2R: dec_o.route = RT_S2R;
            RT_CODE_R2S: dec_o.route = RT_R2S;
            RT_CODE_R2R: dec_o.route = RT_R2R;
            default:     dec_o.route = RT_NONE;
        endcase
        if (rsvd_nz) begin
            dec_o.route = RT_NONE;
        end
    end
endmodule

// File: rtl/script_alu_core.sv
module script_alu_core
    import script_alu_pkg::*;
(
    input  alu_op_e    op_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       cin_i,
    output logic [7:0] res_o,
    output logic       cout_o
);
    logic [8:0] sum;

    always_comb begin
        sum    = {1'b0, a_i} + {1'b0, b_i} + {8'd0, (op_i == OP_ADDC) & cin_i};
        res_o  = b_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_LOAD: res_o = b_i;
            OP_SHL: begin
                res_o  = {a_i[6:0], cin_i};
                cout_o = a_i[7];
            end
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_SHR: begin
                res_o  = {cin_i, a_i[7:1]};
                cout_o = a_i[0];
            end
            OP_ADD, OP_ADDC: begin
                res_o  = sum[7:0];
                cout_o = sum[8];
            end
            default: res_o = b_i;
        endcase
    end
endmodule

// File: rtl/script_reg_alu.sv
module script_reg_alu
    import script_alu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    output logic              insn_done,
    output logic              rf_re,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [7:0]        rf_wdata,
    input  logic [7:0]        rf_rdata,
    output logic [7:0]        sfbr_o,
    output logic              carry_o
);
    localparam int OFF_W = 8;

    unit_state_t state_d, state_q;
    dec_t        dec_in;
    logic [7:0]  opnd_a, opnd_b, alu_res;
    logic        alu_cout;
    logic        reads_reg, writes_reg;

    script_alu_decode u_dec (
        .word_i (insn_word),
        .dec_o  (dec_in)
    );

    always_comb begin
        reads_reg  = (state_q.dec.route == RT_R2S) || (state_q.dec.route == RT_R2R);
        writes_reg = (state_q.dec.route == RT_S2R) || (state_q.dec.route == RT_R2R);
        opnd_a     = (state_q.dec.route == RT_S2R) ? state_q.sfbr : rf_rdata;
        opnd_b     = state_q.dec.use_sfbr ? state_q.sfbr : state_q.dec.imm;
    end

    script_alu_core u_core (
        .op_i   (state_q.dec.op),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .cin_i  (state_q.carry),
        .res_o  (alu_res),
        .cout_o (alu_cout)
    );

    always_comb begin
        state_d   = state_q;
        rf_re     = 1'b0;
        rf_we     = 1'b0;
        insn_done = 1'b0;
        unique case (state_q.fsm)
            ST_IDLE: begin
                if (insn_valid) begin
                    state_d.dec = dec_in;
                    state_d.fsm = ST_READ;
                end
            end
            ST_READ: begin
                rf_re       = reads_reg;
                state_d.fsm = ST_EXEC;
            end
            ST_EXEC: begin
                rf_we = writes_reg;
                if (state_q.dec.route == RT_R2S) begin
                    state_d.sfbr = alu_res;
                end
                if (state_q.dec.route != RT_NONE) begin
                    state_d.carry = alu_cout;
                end
                state_d.fsm = ST_DONE;
            end
            ST_DONE: begin
                insn_done   = 1'b1;
                state_d.fsm = ST_IDLE;
            end
            default: state_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{fsm: ST_IDLE, dec: '0, sfbr: '0, carry: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    generate
        if (ADDR_W >= OFF_W) begin : g_addr_wide
            assign rf_addr = ADDR_W'(state_q.dec.off);
        end else begin : g_addr_narrow
            assign rf_addr = state_q.dec.off[ADDR_W-1:0];
        end
    endgenerate

    assign rf_wdata = alu_res;
    assign sfbr_o   = state_q.sfbr;
    assign carry_o  = state_q.carry;

    // R8: a write strobe is followed by the completion pulse
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> insn_done);

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> !insn_done);

    // R8: read, write and done never overlap
    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_re, rf_we, insn_done}));

    // R8: a read strobe is never repeated on the next cycle
    p_read_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> !rf_re);

    // R7: logical operators and load keep the carry
    p_logic_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.fsm == ST_EXEC && (state_q.dec.op == OP_LOAD || state_q.dec.op == OP_OR ||
         state_q.dec.op == OP_XOR || state_q.dec.op == OP_AND)) |=> $stable(carry_o));

    // R1: only the SFBR-destination routing may change SFBR
    p_sfbr_only_r2s_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.dec.route != RT_R2S) |=> $stable(sfbr_o));

    // R10: nothing is signalled in the cycle after reset
    p_quiet_after_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!insn_done && !rf_we && !rf_re && sfbr_o == 8'd0 && !carry_o));

endmodule

// File: tb/sim_script_reg_alu.sv
module sim_script_reg_alu;
    localparam logic [4:0] K_S2R = 5'h0D;
    localparam logic [4:0] K_R2S = 5'h0E;
    localparam logic [4:0] K_R2R = 5'h0F;
    localparam logic [2:0] O_LD = 3'd0, O_SHL = 3'd1, O_OR = 3'd2, O_XOR = 3'd3,
                           O_AND = 3'd4, O_SHR = 3'd5, O_ADD = 3'd6, O_ADC = 3'd7;

    function automatic logic [31:0] mk(logic [4:0] rt, logic [2:0] op, logic us,
                                       logic [7:0] off, logic [7:0] imm);
        return {rt, op, us, off[6:0], imm, off[7], 7'b0};
    endfunction

    typedef struct packed {
        logic [31:0] w;
        logic [7:0]  a;
        logic [7:0]  m;
        logic [7:0]  s;
        logic        c;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{mk(K_R2S, O_OR,  1'b0, 8'h35, 8'h00), 8'h35, 8'h35, 8'h35, 1'b0}, // R1 copy reg->SFBR
        '{mk(K_R2R, O_LD,  1'b0, 8'h10, 8'hF0), 8'h10, 8'hF0, 8'h35, 1'b0}, // R2 load
        '{mk(K_R2R, O_ADD, 1'b0, 8'h10, 8'h20), 8'h10, 8'h10, 8'h35, 1'b1}, // R5 add overflow
        '{mk(K_R2R, O_SHL, 1'b0, 8'h80, 8'h00), 8'h80, 8'h01, 8'h35, 1'b1}, // R6 R4 upper bank
        '{mk(K_R2R, O_ADC, 1'b0, 8'h11, 8'h0E), 8'h11, 8'h20, 8'h35, 1'b0}, // R5 carry in
        '{mk(K_R2R, O_SHR, 1'b0, 8'h81, 8'h00), 8'h81, 8'h40, 8'h35, 1'b1}, // R6
        '{mk(K_R2R, O_SHR, 1'b0, 8'h81, 8'h00), 8'h81, 8'hA0, 8'h35, 1'b0}, // R6 carry into bit 7
        '{mk(K_S2R, O_OR,  1'b0, 8'h22, 8'h0A), 8'h22, 8'h3F, 8'h35, 1'b0}, // R1 R3
        '{mk(K_R2R, O_XOR, 1'b1, 8'h22, 8'h00), 8'h22, 8'h0A, 8'h35, 1'b0}, // R3 SFBR as data
        '{mk(K_R2S, O_AND, 1'b0, 8'h22, 8'h0F), 8'h22, 8'h0A, 8'h0A, 1'b0}, // R2 and
        '{mk(K_R2R, O_ADD, 1'b0, 8'h30, 8'hFF), 8'h30, 8'h2F, 8'h0A, 1'b1}, // R5
        '{mk(K_R2R, O_XOR, 1'b0, 8'h31, 8'hFF), 8'h31, 8'hCE, 8'h0A, 1'b1}, // R7 carry kept
        '{mk(K_R2R, O_LD,  1'b0, 8'h32, 8'h00), 8'h32, 8'h00, 8'h0A, 1'b1}, // R7 carry kept
        '{mk(K_R2S, O_ADD, 1'b0, 8'h40, 8'hC0), 8'h40, 8'h40, 8'h00, 1'b1}, // R5 into SFBR
        '{mk(K_S2R, O_ADC, 1'b1, 8'h50, 8'h00), 8'h50, 8'h01, 8'h00, 1'b0}, // R5 R3
        '{mk(K_S2R, O_LD,  1'b0, 8'hFF, 8'h77), 8'hFF, 8'h77, 8'h00, 1'b0}, // R2 R4 constant
        '{mk(K_S2R, O_SHL, 1'b0, 8'h60, 8'h00), 8'h60, 8'h00, 8'h00, 1'b0}  // R2 shift of SFBR
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        insn_done, rf_re, rf_we, carry_o;
    logic [7:0]  rf_addr, rf_wdata, sfbr_o;
    logic [7:0]  rf_rdata = '0;
    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    script_reg_alu #(.ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .insn_done(insn_done), .rf_re(rf_re), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .sfbr_o(sfbr_o), .carry_o(carry_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i);
        end else begin
            if (rf_re) rf_rdata <= mem[rf_addr];
            if (rf_we) mem[rf_addr] <= rf_wdata;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = w;
        @(negedge clk);
        insn_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (insn_done) break;
            @(negedge clk);
        end
        chk(insn_done, "R8 done seen", {31'd0, insn_done}, 32'd1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(sfbr_o == 8'h00 && !carry_o, "R10 sfbr/carry", {23'd0, carry_o, sfbr_o}, 32'd0);
        chk(!insn_done && !rf_re && !rf_we, "R10 strobes",
            {29'd0, insn_done, rf_re, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R7: chained vector table
        for (int v = 0; v < NV; v++) begin
            run(VEC[v].w);
            chk(mem[VEC[v].a] == VEC[v].m, $sformatf("R2 vec %0d register", v),
                {24'd0, mem[VEC[v].a]}, {24'd0, VEC[v].m});
            chk(sfbr_o == VEC[v].s, $sformatf("R1 vec %0d sfbr", v),
                {24'd0, sfbr_o}, {24'd0, VEC[v].s});
            chk(carry_o == VEC[v].c, $sformatf("R5 vec %0d carry", v),
                {31'd0, carry_o}, {31'd0, VEC[v].c});
        end

        // R1: unknown routing changes nothing
        run(mk(5'h00, O_ADD, 1'b0, 8'h10, 8'h01));
        chk(mem[8'h10] == 8'h10, "R1 unknown route reg", {24'd0, mem[8'h10]}, 32'h10);
        chk(sfbr_o == 8'h00 && !carry_o, "R1 unknown route state",
            {23'd0, carry_o, sfbr_o}, 32'd0);

        // R1: reserved bits set
        run(mk(K_R2R, O_LD, 1'b0, 8'h13, 8'h99) | 32'h1);
        chk(mem[8'h13] == 8'h13, "R1 reserved bits", {24'd0, mem[8'h13]}, 32'h13);

        // R8: exact cycle sequence
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = mk(K_R2R, O_LD, 1'b0, 8'h12, 8'hAB);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(rf_re && !rf_we && rf_addr == 8'h12, "R8 read cycle",
            {22'd0, rf_re, rf_we, rf_addr}, {22'd0, 2'b10, 8'h12});
        @(negedge clk);
        chk(rf_we && !insn_done && rf_wdata == 8'hAB, "R8 write cycle",
            {22'd0, rf_we, insn_done, rf_wdata}, {22'd0, 2'b10, 8'hAB});
        @(negedge clk);
        chk(insn_done && !rf_we, "R8 done cycle", {30'd0, insn_done, rf_we}, 32'd2);
        @(negedge clk);
        chk(!insn_done, "R8 done one cycle", {31'd0, insn_done}, 32'd0);
        chk(mem[8'h12] == 8'hAB, "R8 stored", {24'd0, mem[8'h12]}, 32'hAB);

        // R9: valid while busy is ignored
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word  = mk(K_R2R, O_LD, 1'b0, 8'h71, 8'h55);
        @(negedge clk);
        insn_word  = mk(K_R2R, O_LD, 1'b0, 8'h70, 8'h99);
        @(negedge clk);
        insn_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem[8'h71] == 8'h55, "R9 first taken", {24'd0, mem[8'h71]}, 32'h55);
        chk(mem[8'h70] == 8'h70, "R9 busy ignored", {24'd0, mem[8'h70]}, 32'h70);

        finish_run();
    end
endmodule